// File: doc/BRIEF.md
# Bridge Error Status and Capture Unit

This block gathers error events from a bus bridge into one status register and keeps a frozen snapshot of the transaction that raised the first error. Six single-cycle event inputs report master abort, target abort, address parity error, a system error received from the bus, a data parity error seen as master and a data parity error seen as target. Each cycle the bridge also presents the current transaction's address, data and control fields. When no bus error flag is pending, an event loads those three values into capture registers. While any bus error flag stays pending, the capture registers keep their contents and later events only set flags.

Software reaches the unit through a small register port. Each access carries a beat count. A configuration access whose count is not exactly one is refused. It sets an illegal-access flag, a refused read returns all ones, and a refused write changes nothing. Status bits are cleared by writing ones. Two state machines sit at the core. The capture machine has the states OPEN (snapshot may load) and FROZEN (snapshot held). Its OPEN-to-FROZEN transition fires when a bus error flag becomes set, and its FROZEN-to-OPEN transition fires when the last bus error flag is cleared with no new event in that cycle. The access machine has the states IDLE, READ and REJECT. It goes to READ after a legal read, to REJECT after a refused read, and back to IDLE after a write or when no request is present.

Top module: `bridge_err_capture`

## Requirements
- R1: After reset every status bit is 0, the three capture registers are 0 and `acc_rvalid` is 0.
- R2: A 1 on bit i of `evt_err` sets status bit i at the next clock edge. The bit map is: 0 master abort, 1 target abort, 2 address parity, 3 received system error, 4 master data parity, 5 target data parity.
- R3: A legal write to offset 0 clears each status bit 0..6 whose `acc_wdata` bit is 1 and leaves the others unchanged. Bit 7 ignores writes.
- R4: When an event and a clear hit the same status bit in one cycle, the bit stays set.
- R5: When status bits 0..5 are all 0, any event loads `txn_addr`, `txn_data` and `txn_ctrl` of that cycle into the capture registers. These read, zero-extended, at offsets 1, 2 and 3.
- R6: While any of status bits 0..5 is set, the capture registers keep their values, and further events only set flags.
- R7: Status bit 7 (capture held, read-only) reads 1 exactly when any of bits 0..5 is set. Once they are all cleared, the next event loads the capture registers again.
- R8: Any access whose `acc_beats` is not 1 sets status bit 6 (illegal access). Bit 6 affects neither the capture registers nor bit 7.
- R9: A read with `acc_beats` not equal to 1 returns all ones on `acc_rdata`, with `acc_rvalid` high in the following cycle.
- R10: A write with `acc_beats` not equal to 1 is discarded: no status bit is cleared, even when it targets offset 0.
- R11: A legal read raises `acc_rvalid` for one cycle, the cycle after the request. It returns the register value as it stood before that clock edge. Offsets 4 and above read 0, writes to offsets 1..3 have no effect, and writes never raise `acc_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_err | input | 6 | Bus error event pulses, bit map as in R2 |
| txn_addr | input | AW (32) | Current transaction address |
| txn_data | input | DW (32) | Current transaction data |
| txn_ctrl | input | CW (8) | Current transaction control field |
| acc_req | input | 1 | Register access request, one cycle per access |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | RAW (4) | Register offset |
| acc_wdata | input | REG_W (32) | Write data |
| acc_beats | input | BEAT_W (4) | Beat count of the access; only 1 is legal |
| acc_rvalid | output | 1 | Read data valid, one cycle after a read request |
| acc_rdata | output | REG_W (32) | Read data |

## Verification
The bench targets the moment an event arrives while a flag is already pending. A design that reloads there would show the newer address in the capture registers. It also sends an event on the same cycle as a clear of that bit, which a design that lets the clear win would drop. It clears the last bus flag and then sends a fresh event, so that a unit stuck frozen would keep stale capture data. It issues refused reads and writes aimed at the status register, where a design that honoured them would return real data or wipe flags. It also raises the illegal-access flag alone, to catch a unit that lets that flag freeze the capture registers.

// File: rtl/errcap_pkg.sv
package errcap_pkg;

    localparam int N_BUS_ERR = 6;
    localparam int N_FLAG    = N_BUS_ERR + 1;
    localparam int BIT_IRA   = N_BUS_ERR;
    localparam int BIT_HELD  = N_FLAG;

    localparam int OFS_STATUS = 0;
    localparam int OFS_CADDR  = 1;
    localparam int OFS_CDATA  = 2;
    localparam int OFS_CCTRL  = 3;

    typedef enum logic {
        HOLD_OPEN,
        HOLD_FROZEN
    } hold_state_t;

    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_READ,
        ACC_REJECT
    } acc_state_t;

endpackage

// File: rtl/errcap_flags.sv
module errcap_flags #(
    parameter int N_BUS = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_BUS-1:0] bus_evt,
    input  logic             ira_evt,
    input  logic             clr_en,
    input  logic [N_BUS:0]   clr_mask,
    output logic [N_BUS:0]   flags_q,
    output logic             pending_next
);

    localparam int NF = N_BUS + 1;

    logic [NF-1:0] set_vec;
    logic [NF-1:0] clr_vec;
    logic [NF-1:0] flags_d;

    always_comb begin
        set_vec = {ira_evt, bus_evt};
        clr_vec = clr_en ? clr_mask : '0;
    end

    for (genvar i = 0; i < NF; i++) begin : g_flag
        // a set in the same cycle overrides a clear
        always_comb flags_d[i] = set_vec[i] | (flags_q[i] & ~clr_vec[i]);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flags_q[i] <= 1'b0;
            end else begin
                flags_q[i] <= flags_d[i];
            end
        end
    end

    always_comb pending_next = |flags_d[N_BUS-1:0];

endmodule

// File: rtl/errcap_hold.sv
module errcap_hold
    import errcap_pkg::*;
#(
    parameter int N_BUS = 6,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int CW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_BUS-1:0] bus_evt,
    input  logic             pending_next,
    input  logic [AW-1:0]    txn_addr,
    input  logic [DW-1:0]    txn_data,
    input  logic [CW-1:0]    txn_ctrl,
    output logic             held,
    output logic [AW-1:0]    cap_addr,
    output logic [DW-1:0]    cap_data,
    output logic [CW-1:0]    cap_ctrl
);

    hold_state_t state_q;
    hold_state_t state_d;
    logic        load;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HOLD_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HOLD_OPEN:   if (pending_next)  state_d = HOLD_FROZEN;
            HOLD_FROZEN: if (!pending_next) state_d = HOLD_OPEN;
            default:     state_d = HOLD_OPEN;
        endcase
    end

    always_comb begin
        held = (state_q == HOLD_FROZEN);
        load = (state_q == HOLD_OPEN) && (|bus_evt);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_data <= '0;
            cap_ctrl <= '0;
        end else if (load) begin
            cap_addr <= txn_addr;
            cap_data <= txn_data;
            cap_ctrl <= txn_ctrl;
        end
    end

endmodule

// File: rtl/errcap_port.sv
module errcap_port
    import errcap_pkg::*;
#(
    parameter int N_BUS  = 6,
    parameter int RAW    = 4,
    parameter int REG_W  = 32,
    parameter int BEAT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [RAW-1:0]    addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [BEAT_W-1:0] beats,
    input  logic [N_BUS:0]    flags_q,
    input  logic              held,
    input  logic [REG_W-1:0]  cap_addr_x,
    input  logic [REG_W-1:0]  cap_data_x,
    input  logic [REG_W-1:0]  cap_ctrl_x,
    output logic              clr_en,
    output logic [N_BUS:0]    clr_mask,
    output logic              ira_evt,
    output logic              rvalid,
    output logic [REG_W-1:0]  rdata
);

    acc_state_t       state_q;
    acc_state_t       state_d;
    logic             legal;
    logic [REG_W-1:0] rd_mux;
    logic [REG_W-1:0] rdata_q;

    always_comb begin
        legal    = (beats == BEAT_W'(1));
        ira_evt  = req && !legal;
        clr_en   = req && we && legal && (addr == RAW'(OFS_STATUS));
        clr_mask = wdata[N_BUS:0];
    end

    always_comb begin
        unique case (addr)
            RAW'(OFS_STATUS): rd_mux = REG_W'({held, flags_q});
            RAW'(OFS_CADDR):  rd_mux = cap_addr_x;
            RAW'(OFS_CDATA):  rd_mux = cap_data_x;
            RAW'(OFS_CCTRL):  rd_mux = cap_ctrl_x;
            default:          rd_mux = '0;
        endcase
    end

    always_comb begin
        state_d = ACC_IDLE;
        unique case (state_q)
            ACC_IDLE, ACC_READ, ACC_REJECT: begin
                if (req && !we) begin
                    state_d = legal ? ACC_READ : ACC_REJECT;
                end
            end
            default: state_d = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == ACC_READ) begin
                rdata_q <= rd_mux;
            end
        end
    end

    always_comb begin
        rvalid = (state_q != ACC_IDLE);
        unique case (state_q)
            ACC_READ:   rdata = rdata_q;
            ACC_REJECT: rdata = '1;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/bridge_err_capture.sv
module bridge_err_capture
    import errcap_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int CW     = 8,
    parameter int RAW    = 4,
    parameter int REG_W  = 32,
    parameter int BEAT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_BUS_ERR-1:0] evt_err,
    input  logic [AW-1:0]        txn_addr,
    input  logic [DW-1:0]        txn_data,
    input  logic [CW-1:0]        txn_ctrl,
    input  logic                 acc_req,
    input  logic                 acc_we,
    input  logic [RAW-1:0]       acc_addr,
    input  logic [REG_W-1:0]     acc_wdata,
    input  logic [BEAT_W-1:0]    acc_beats,
    output logic                 acc_rvalid,
    output logic [REG_W-1:0]     acc_rdata
);

    logic [N_BUS_ERR:0] flags_q;
    logic               pending_next;
    logic               ira_evt;
    logic               clr_en;
    logic [N_BUS_ERR:0] clr_mask;
    logic               held;
    logic [AW-1:0]      cap_addr;
    logic [DW-1:0]      cap_data;
    logic [CW-1:0]      cap_ctrl;
    logic [REG_W-1:0]   cap_addr_x;
    logic [REG_W-1:0]   cap_data_x;
    logic [REG_W-1:0]   cap_ctrl_x;

    always_comb begin
        cap_addr_x = REG_W'(cap_addr);
        cap_data_x = REG_W'(cap_data);
        cap_ctrl_x = REG_W'(cap_ctrl);
    end

    errcap_flags #(.N_BUS(N_BUS_ERR)) u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_evt      (evt_err),
        .ira_evt      (ira_evt),
        .clr_en       (clr_en),
        .clr_mask     (clr_mask),
        .flags_q      (flags_q),
        .pending_next (pending_next)
    );

    errcap_hold #(.N_BUS(N_BUS_ERR), .AW(AW), .DW(DW), .CW(CW)) u_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_evt      (evt_err),
        .pending_next (pending_next),
        .txn_addr     (txn_addr),
        .txn_data     (txn_data),
        .txn_ctrl     (txn_ctrl),
        .held         (held),
        .cap_addr     (cap_addr),
        .cap_data     (cap_data),
        .cap_ctrl     (cap_ctrl)
    );

    errcap_port #(.N_BUS(N_BUS_ERR), .RAW(RAW), .REG_W(REG_W), .BEAT_W(BEAT_W)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (acc_req),
        .we         (acc_we),
        .addr       (acc_addr),
        .wdata      (acc_wdata),
        .beats      (acc_beats),
        .flags_q    (flags_q),
        .held       (held),
        .cap_addr_x (cap_addr_x),
        .cap_data_x (cap_data_x),
        .cap_ctrl_x (cap_ctrl_x),
        .clr_en     (clr_en),
        .clr_mask   (clr_mask),
        .ira_evt    (ira_evt),
        .rvalid     (acc_rvalid),
        .rdata      (acc_rdata)
    );

endmodule

// File: rtl/errcap_checker.sv
module errcap_checker #(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int CW     = 8,
    parameter int RAW    = 4,
    parameter int REG_W  = 32,
    parameter int BEAT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [5:0]        evt_err,
    input logic [AW-1:0]     txn_addr,
    input logic [DW-1:0]     txn_data,
    input logic [CW-1:0]     txn_ctrl,
    input logic              acc_req,
    input logic              acc_we,
    input logic [RAW-1:0]    acc_addr,
    input logic [REG_W-1:0]  acc_wdata,
    input logic [BEAT_W-1:0] acc_beats,
    input logic              acc_rvalid,
    input logic [REG_W-1:0]  acc_rdata,
    input logic [6:0]        flags_q,
    input logic              held,
    input logic [AW-1:0]     cap_addr,
    input logic [DW-1:0]     cap_data,
    input logic [CW-1:0]     cap_ctrl
);

    logic       bad_acc;
    logic [6:0] keep;

    always_comb begin
        bad_acc = acc_req && (acc_beats != BEAT_W'(1));
        if (acc_req && acc_we && !bad_acc && (acc_addr == RAW'(0))) begin
            keep = flags_q & ~acc_wdata[6:0];
        end else begin
            keep = flags_q;
        end
    end

    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_err) |=> ((flags_q[5:0] & $past(evt_err)) == $past(evt_err)));

    assert_w1c_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_q & $past(keep)) == $past(keep)));

    assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && (|evt_err)) |=> (cap_addr == $past(txn_addr) &&
                                   cap_data == $past(txn_data) &&
                                   cap_ctrl == $past(txn_ctrl)));

    assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> ($stable(cap_addr) && $stable(cap_data) && $stable(cap_ctrl)));

    assert_held_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        held == (|flags_q[5:0]));

    assert_ira_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bad_acc |=> flags_q[6]);

    assert_bad_read_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_acc && !acc_we) |=> (acc_rvalid && acc_rdata == '1));

    assert_bad_write_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_acc && acc_we) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    assert_rvalid_origin_R11: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rvalid |-> $past(acc_req && !acc_we));

endmodule

bind bridge_err_capture errcap_checker #(
    .AW(AW), .DW(DW), .CW(CW), .RAW(RAW), .REG_W(REG_W), .BEAT_W(BEAT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_err    (evt_err),
    .txn_addr   (txn_addr),
    .txn_data   (txn_data),
    .txn_ctrl   (txn_ctrl),
    .acc_req    (acc_req),
    .acc_we     (acc_we),
    .acc_addr   (acc_addr),
    .acc_wdata  (acc_wdata),
    .acc_beats  (acc_beats),
    .acc_rvalid (acc_rvalid),
    .acc_rdata  (acc_rdata),
    .flags_q    (flags_q),
    .held       (held),
    .cap_addr   (cap_addr),
    .cap_data   (cap_data),
    .cap_ctrl   (cap_ctrl)
);

// File: tb/bridge_err_capture_bench.sv
`timescale 1ns/1ps
module bridge_err_capture_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  evt_err = '0;
    logic [31:0] txn_addr = '0;
    logic [31:0] txn_data = '0;
    logic [7:0]  txn_ctrl = '0;
    logic        acc_req = 1'b0;
    logic        acc_we = 1'b0;
    logic [3:0]  acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [3:0]  acc_beats = 4'd1;
    logic        acc_rvalid;
    logic [31:0] acc_rdata;

    always #4 clk = ~clk;

    bridge_err_capture u_bridge_err_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_err    (evt_err),
        .txn_addr   (txn_addr),
        .txn_data   (txn_data),
        .txn_ctrl   (txn_ctrl),
        .acc_req    (acc_req),
        .acc_we     (acc_we),
        .acc_addr   (acc_addr),
        .acc_wdata  (acc_wdata),
        .acc_beats  (acc_beats),
        .acc_rvalid (acc_rvalid),
        .acc_rdata  (acc_rdata)
    );

    int  n_vec  = 0;
    int  n_bad  = 0;
    bit  done   = 1'b0;

    bit [6:0]  m_flags;
    bit [31:0] m_ca, m_cd;
    bit [7:0]  m_cc;
    bit        m_rv;
    bit [31:0] m_rd;

    function automatic bit [31:0] model_read(input bit [3:0] a);
        case (a)
            4'd0:    return {24'd0, |m_flags[5:0], m_flags};
            4'd1:    return m_ca;
            4'd2:    return m_cd;
            4'd3:    return {24'd0, m_cc};
            default: return 32'd0;
        endcase
    endfunction

    task automatic compare(input string tag);
        n_vec++;
        if (acc_rvalid !== m_rv) begin
            n_bad++;
            $display("FAIL %s rvalid actual=%0b expected=%0b", tag, acc_rvalid, m_rv);
        end else if (m_rv && acc_rdata !== m_rd) begin
            n_bad++;
            $display("FAIL %s rdata actual=%08h expected=%08h", tag, acc_rdata, m_rd);
        end
    endtask

    task automatic tick(input bit [5:0] ev, input bit [31:0] ta, input bit [31:0] td,
                        input bit [7:0] tc, input bit rq, input bit wr, input bit [3:0] ad,
                        input bit [31:0] wd, input bit [3:0] bt, input string tag);
        bit legal;
        bit [6:0] clr;
        evt_err = ev; txn_addr = ta; txn_data = td; txn_ctrl = tc;
        acc_req = rq; acc_we = wr; acc_addr = ad; acc_wdata = wd; acc_beats = bt;
        @(posedge clk);
        legal = (bt == 4'd1);
        m_rv  = rq && !wr;
        m_rd  = legal ? model_read(ad) : 32'hFFFF_FFFF;
        clr   = (rq && wr && legal && ad == 4'd0) ? wd[6:0] : 7'd0;
        if (m_flags[5:0] == 6'd0 && ev != 6'd0) begin
            m_ca = ta; m_cd = td; m_cc = tc;
        end
        m_flags = (m_flags & ~clr) | {rq && !legal, ev};
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(input string tag);
        tick(6'd0, 32'd0, 32'd0, 8'd0, 1'b0, 1'b0, 4'd0, 32'd0, 4'd1, tag);
    endtask

    task automatic rd(input bit [3:0] ad, input string tag);
        tick(6'd0, 32'd0, 32'd0, 8'd0, 1'b1, 1'b0, ad, 32'd0, 4'd1, tag);
    endtask

    task automatic wr(input bit [3:0] ad, input bit [31:0] wd, input string tag);
        tick(6'd0, 32'd0, 32'd0, 8'd0, 1'b1, 1'b1, ad, wd, 4'd1, tag);
    endtask

    task automatic ev(input bit [5:0] e, input bit [31:0] ta, input bit [31:0] td,
                      input bit [7:0] tc, input string tag);
        tick(e, ta, td, tc, 1'b0, 1'b0, 4'd0, 32'd0, 4'd1, tag);
    endtask

    task automatic read_all(input string tag);
        for (int a = 0; a < 4; a++) rd(a[3:0], tag);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R11 actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        m_flags = '0; m_ca = '0; m_cd = '0; m_cc = '0; m_rv = 1'b0; m_rd = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare("R1 reset rvalid");
        read_all("R1 reset values");
        rd(4'd7, "R11 unmapped offset");

        // first error loads capture
        ev(6'b000001, 32'hA000_0010, 32'hD000_0001, 8'h3C, "R2 master abort");
        read_all("R5 first capture");
        // second error while held
        ev(6'b000100, 32'hB111_2220, 32'hD222_0002, 8'h55, "R6 later error no reload");
        read_all("R6 capture frozen");
        ev(6'b001010, 32'hC000_0004, 32'h1, 8'h1, "R2 two sources together");
        rd(4'd0, "R2 status after multi event");

        // clearing
        wr(4'd0, 32'h0000_0001, "R3 clear bit0");
        rd(4'd0, "R3 status after clear");
        wr(4'd0, 32'h0000_0080, "R3 write held bit ignored");
        rd(4'd0, "R3 held bit kept");
        tick(6'b010000, 32'hE0, 32'hE1, 8'hE2, 1'b1, 1'b1, 4'd0, 32'h0000_0010, 4'd1,
             "R4 event beats clear");
        rd(4'd0, "R4 bit4 stays set");
        wr(4'd1, 32'h1234_5678, "R11 write to capture ignored");
        rd(4'd1, "R11 capture unchanged");

        // clear everything, reload
        wr(4'd0, 32'h0000_007F, "R3 clear all");
        rd(4'd0, "R7 held drops");
        ev(6'b100000, 32'hF00D_0000, 32'hCAFE_0001, 8'h7E, "R7 reload after clear");
        read_all("R7 new capture");

        // illegal accesses
        tick(6'd0, 0, 0, 0, 1'b1, 1'b0, 4'd1, 32'd0, 4'd2, "R9 multi beat read ones");
        tick(6'd0, 0, 0, 0, 1'b1, 1'b0, 4'd0, 32'd0, 4'd0, "R9 zero beat read ones");
        rd(4'd0, "R8 illegal flag set");
        tick(6'd0, 0, 0, 0, 1'b1, 1'b1, 4'd0, 32'hFFFF_FFFF, 4'd4, "R10 bad write dropped");
        read_all("R10 nothing cleared");
        wr(4'd0, 32'h0000_0040, "R3 clear illegal flag");
        rd(4'd0, "R3 illegal flag cleared");

        // illegal flag alone does not freeze capture
        wr(4'd0, 32'h0000_007F, "R3 clear all again");
        tick(6'd0, 0, 0, 0, 1'b1, 1'b1, 4'd2, 32'd0, 4'd3, "R8 illegal alone");
        rd(4'd0, "R8 held stays clear");
        ev(6'b000010, 32'h0BAD_0BAD, 32'h0000_0F0F, 8'h99, "R8 load despite illegal flag");
        read_all("R8 capture reloaded");

        // back to back reads and an event in a read cycle
        tick(6'b001000, 32'h1, 32'h2, 8'h3, 1'b1, 1'b0, 4'd0, 32'd0, 4'd1,
             "R11 read shows pre-edge value");
        rd(4'd0, "R11 read after event");
        idle("R11 rvalid single cycle");
        idle("R11 idle");
        finish_run();
    end

endmodule